// File: doc/BRIEF.md
# Operand Effective Address Generator

This block computes the memory operand address for a decoded instruction. The inputs are the addressing byte fields (mode and register/memory selector), the scale/index/base byte fields, a displacement together with its size code, and the address-size mode. It also takes an optional segment override and the contents of the eight 32-bit general registers on one flat bus. The block returns the effective address, the segment to use, and a flag that marks a register operand.

Two addressing variants are built side by side. The 16-bit variant uses fixed base/index register pairs, and any form that involves BP defaults to the stack segment. The 32-bit variant uses a single base register or a scaled index plus base, and it handles the special selector codes for "no index" and "no base". The address-size input picks one of the two results. An optional output register stage, chosen by parameter, gives a one-cycle latency.

Top module: `eagen_top`

## Requirements
- R1: In 16-bit mode (mode32=0) with mod_f other than 11, rm_f 0..7 selects the terms BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX, using the low 16 bits of registers 3 (BX), 5 (BP), 6 (SI) and 7 (DI).
- R2: In 16-bit mode, mod_f=00 with rm_f=110 uses no register term: the address is the displacement alone.
- R3: Segment codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. In 16-bit mode without override, a form that includes BP gives SS and every other form gives DS.
- R4: disp_sz code 0 adds nothing, 1 adds disp_i[7:0] sign-extended, 2 adds disp_i[15:0] zero-extended, and 3 adds all 32 bits of disp_i.
- R5: With mod_f=11, is_reg_o is 1 and ea_o is 0. The segment is DS, or the override when one is given. With any other mod_f, is_reg_o is 0.
- R6: In 32-bit mode without a scale/index/base byte, rm_f selects register rm_f (0=EAX .. 7=EDI). rm_f=100 instead means the scale/index/base fields are used. mod_f=00 with rm_f=101 means the displacement alone.
- R7: With the scale/index/base fields in use, the address is base + (index register << sib_scale) + displacement. The fields map to that byte as sib_scale = bits 7:6, sib_index = bits 5:3, sib_base = bits 2:0.
- R8: sib_index=100 adds no index term.
- R9: sib_base=101 adds no base when mod_f=00 and adds EBP when mod_f is 01 or 10.
- R10: In 32-bit mode without override, a form whose base register is ESP or EBP gives SS. Every other form gives DS, including a form that uses EBP only as the index.
- R11: When seg_ovr_en is 1, seg_o equals seg_ovr_sel in every mode.
- R12: A 16-bit address wraps modulo 2^16 and returns with ea_o[31:16]=0. A 32-bit address wraps modulo 2^32.
- R13: With REG_OUT=1 (the default), the outputs show the result for the inputs present at a rising clock edge from that edge on. An active-low asynchronous reset forces ea_o=0, seg_o=0 and is_reg_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | Address size: 1 = 32-bit forms, 0 = 16-bit forms |
| mod_f | input | 2 | Addressing byte mode field |
| rm_f | input | 3 | Addressing byte register/memory field |
| sib_scale | input | 2 | Scale field, index shifted left by this amount |
| sib_index | input | 3 | Index register number, 100 = none |
| sib_base | input | 3 | Base register number, 101 = special |
| disp_i | input | 32 | Raw displacement bits |
| disp_sz | input | 2 | Displacement size code |
| seg_ovr_en | input | 1 | Segment override present |
| seg_ovr_sel | input | 3 | Override segment code |
| gpr_flat | input | 256 | Eight 32-bit registers, register n at bits 32n+31:32n |
| ea_o | output | 32 | Effective address |
| seg_o | output | 3 | Selected segment code |
| is_reg_o | output | 1 | Operand is a register, no address |

## Verification
With the default output register, the address, segment and register flag for a set of inputs are all due at the first rising edge after those inputs settle. None of them appears earlier. The bench applies each stimulus on a falling edge and reads the results on the next falling edge, half a period after the capturing edge. A directed test changes the inputs and looks before the next rising edge, to confirm that the previous result is still held. Reset is checked while it is held and again when it is asserted in the middle of operation, because it clears the outputs without a clock.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

   typedef enum logic [2:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_e;

   typedef enum logic [1:0] {
      DSZ_NONE  = 2'd0,
      DSZ_BYTE  = 2'd1,
      DSZ_WORD  = 2'd2,
      DSZ_DWORD = 2'd3
   } dsz_e;

   // register numbers used by fixed forms
   localparam int unsigned REG_BX = 3;
   localparam int unsigned REG_SP = 4;
   localparam int unsigned REG_BP = 5;
   localparam int unsigned REG_SI = 6;
   localparam int unsigned REG_DI = 7;

   // selector codes with a special meaning
   localparam logic [2:0] SEL_ESC  = 3'b100;
   localparam logic [2:0] SEL_NOBX = 3'b101;
   localparam logic [2:0] SEL_D16  = 3'b110;

   function automatic logic [31:0] widen_disp(input logic [31:0] raw, input logic [1:0] sz);
      logic [31:0] r;
      case (sz)
         DSZ_BYTE:  r = {{24{raw[7]}}, raw[7:0]};
         DSZ_WORD:  r = {16'h0000, raw[15:0]};
         DSZ_DWORD: r = raw;
         default:   r = 32'h0000_0000;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/eagen_form16.sv
module eagen_form16
   import eagen_pkg::*;
(
   input  logic [1:0]  mod_f,
   input  logic [2:0]  rm_f,
   input  logic [15:0] bx_v,
   input  logic [15:0] bp_v,
   input  logic [15:0] si_v,
   input  logic [15:0] di_v,
   input  logic [15:0] disp_v,
   output logic [15:0] ea_o,
   output logic        via_bp_o
);

   logic [15:0] left_t;
   logic [15:0] right_t;

   always_comb begin
      left_t   = 16'h0000;
      right_t  = 16'h0000;
      via_bp_o = 1'b0;
      case (rm_f)
         3'd0: begin left_t = bx_v; right_t = si_v; end
         3'd1: begin left_t = bx_v; right_t = di_v; end
         3'd2: begin left_t = bp_v; right_t = si_v; via_bp_o = 1'b1; end
         3'd3: begin left_t = bp_v; right_t = di_v; via_bp_o = 1'b1; end
         3'd4: left_t = si_v;
         3'd5: left_t = di_v;
         3'd6: begin
            if (mod_f != 2'b00) begin
               left_t   = bp_v;
               via_bp_o = 1'b1;
            end
         end
         default: left_t = bx_v;
      endcase
   end

   // modulo 2^16 sum by width
   assign ea_o = left_t + right_t + disp_v;

endmodule

// File: rtl/eagen_form32.sv
module eagen_form32
   import eagen_pkg::*;
#(
   parameter int unsigned GPR_N = 8,
   parameter int unsigned GPR_W = 32,
   localparam int unsigned SEL_W = $clog2(GPR_N)
) (
   input  logic [1:0]                  mod_f,
   input  logic [SEL_W-1:0]            rm_f,
   input  logic [1:0]                  sib_scale,
   input  logic [SEL_W-1:0]            sib_index,
   input  logic [SEL_W-1:0]            sib_base,
   input  logic [GPR_N-1:0][GPR_W-1:0] gpr_i,
   input  logic [GPR_W-1:0]            disp_v,
   output logic [GPR_W-1:0]            ea_o,
   output logic                        via_stack_o
);

   logic [GPR_W-1:0] base_t;
   logic [GPR_W-1:0] index_t;

   always_comb begin
      base_t      = '0;
      index_t     = '0;
      via_stack_o = 1'b0;
      if (rm_f == SEL_ESC) begin
         if (sib_index != SEL_ESC)
            index_t = gpr_i[sib_index] << sib_scale;
         if (sib_base == SEL_NOBX && mod_f == 2'b00) begin
            base_t = '0;
         end else begin
            base_t      = gpr_i[sib_base];
            via_stack_o = (sib_base == SEL_ESC) || (sib_base == SEL_NOBX);
         end
      end else if (rm_f == SEL_NOBX && mod_f == 2'b00) begin
         base_t = '0;
      end else begin
         base_t      = gpr_i[rm_f];
         via_stack_o = (rm_f == SEL_NOBX);
      end
   end

   // modulo 2^GPR_W sum by width
   assign ea_o = base_t + index_t + disp_v;

endmodule

// File: rtl/eagen_seg_pick.sv
module eagen_seg_pick
   import eagen_pkg::*;
(
   input  logic       is_reg_i,
   input  logic       mode32,
   input  logic       bp16_i,
   input  logic       stk32_i,
   input  logic       ovr_en_i,
   input  logic [2:0] ovr_sel_i,
   output logic [2:0] seg_o
);

   logic stack_dflt;

   always_comb begin
      if (is_reg_i)
         stack_dflt = 1'b0;
      else if (mode32)
         stack_dflt = stk32_i;
      else
         stack_dflt = bp16_i;
   end

   always_comb begin
      if (ovr_en_i)
         seg_o = ovr_sel_i;
      else if (stack_dflt)
         seg_o = SEG_SS;
      else
         seg_o = SEG_DS;
   end

endmodule

// File: rtl/eagen_top.sv
module eagen_top
   import eagen_pkg::*;
#(
   parameter int unsigned GPR_N   = 8,
   parameter int unsigned GPR_W   = 32,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned SEL_W  = $clog2(GPR_N),
   localparam int unsigned FLAT_W = GPR_N * GPR_W,
   localparam int unsigned HALF_W = GPR_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode32,
   input  logic [1:0]        mod_f,
   input  logic [2:0]        rm_f,
   input  logic [1:0]        sib_scale,
   input  logic [2:0]        sib_index,
   input  logic [2:0]        sib_base,
   input  logic [31:0]       disp_i,
   input  logic [1:0]        disp_sz,
   input  logic              seg_ovr_en,
   input  logic [2:0]        seg_ovr_sel,
   input  logic [FLAT_W-1:0] gpr_flat,
   output logic [GPR_W-1:0]  ea_o,
   output logic [2:0]        seg_o,
   output logic              is_reg_o
);

   // elaboration checks on the parameter set
   if (GPR_N != 8) begin : g_bad_n
      $error("eagen_top: GPR_N must be 8");
   end
   if (GPR_W != 32) begin : g_bad_w
      $error("eagen_top: GPR_W must be 32");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("eagen_top: selector width must be 3");
   end

   // unpack register bus
   logic [GPR_N-1:0][GPR_W-1:0] gpr_a;
   for (genvar g = 0; g < GPR_N; g++) begin : g_unpack
      assign gpr_a[g] = gpr_flat[g*GPR_W +: GPR_W];
   end

   logic [31:0]       disp_w;
   logic [15:0]       ea16;
   logic              bp16;
   logic [GPR_W-1:0]  ea32;
   logic              stk32;
   logic              reg_c;
   logic [GPR_W-1:0]  ea_c;
   logic [2:0]        seg_c;

   assign disp_w = widen_disp(disp_i, disp_sz);
   assign reg_c  = (mod_f == 2'b11);

   eagen_form16 u_form16 (
      .mod_f    (mod_f),
      .rm_f     (rm_f),
      .bx_v     (gpr_a[REG_BX][HALF_W-1:0]),
      .bp_v     (gpr_a[REG_BP][HALF_W-1:0]),
      .si_v     (gpr_a[REG_SI][HALF_W-1:0]),
      .di_v     (gpr_a[REG_DI][HALF_W-1:0]),
      .disp_v   (disp_w[15:0]),
      .ea_o     (ea16),
      .via_bp_o (bp16)
   );

   eagen_form32 #(
      .GPR_N (GPR_N),
      .GPR_W (GPR_W)
   ) u_form32 (
      .mod_f       (mod_f),
      .rm_f        (rm_f),
      .sib_scale   (sib_scale),
      .sib_index   (sib_index),
      .sib_base    (sib_base),
      .gpr_i       (gpr_a),
      .disp_v      (disp_w),
      .ea_o        (ea32),
      .via_stack_o (stk32)
   );

   eagen_seg_pick u_seg (
      .is_reg_i  (reg_c),
      .mode32    (mode32),
      .bp16_i    (bp16),
      .stk32_i   (stk32),
      .ovr_en_i  (seg_ovr_en),
      .ovr_sel_i (seg_ovr_sel),
      .seg_o     (seg_c)
   );

   always_comb begin
      if (reg_c)
         ea_c = '0;
      else if (mode32)
         ea_c = ea32;
      else
         ea_c = {{(GPR_W-16){1'b0}}, ea16};
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ea_o     <= '0;
            seg_o    <= 3'd0;
            is_reg_o <= 1'b0;
         end else begin
            ea_o     <= ea_c;
            seg_o    <= seg_c;
            is_reg_o <= reg_c;
         end
      end

      // R5
      regflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_f == 2'b11) |=> (is_reg_o && ea_o == '0));
      // R5
      memflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_f != 2'b11) |=> !is_reg_o);
      // R11
      override_chk: assert property (@(posedge clk) disable iff (!rst_n)
         seg_ovr_en |=> (seg_o == $past(seg_ovr_sel)));
      // R12
      wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !mode32 |=> (ea_o[GPR_W-1:16] == '0));
      // R3
      bpseg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode32 && !seg_ovr_en && mod_f != 2'b11 && (rm_f == 3'd2 || rm_f == 3'd3))
         |=> (seg_o == SEG_SS));
      // R10
      espseg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode32 && !seg_ovr_en && mod_f != 2'b11 && rm_f == 3'b100 && sib_base == 3'b100)
         |=> (seg_o == SEG_SS));
   end else begin : g_comb
      assign ea_o     = ea_c;
      assign seg_o    = seg_c;
      assign is_reg_o = reg_c;

      // R5
      regflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_f == 2'b11) |-> (is_reg_o && ea_o == '0));
      // R11
      override_chk: assert property (@(posedge clk) disable iff (!rst_n)
         seg_ovr_en |-> (seg_o == seg_ovr_sel));
      // R12
      wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !mode32 |-> (ea_o[GPR_W-1:16] == '0));
      // R3
      bpseg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode32 && !seg_ovr_en && mod_f != 2'b11 && (rm_f == 3'd2 || rm_f == 3'd3))
         |-> (seg_o == SEG_SS));
   end

endmodule

// File: tb/eagen_top_tb_top.sv
module eagen_top_tb_top;

   typedef struct packed {
      logic        m32;
      logic [1:0]  md;
      logic [2:0]  rm;
      logic [1:0]  sc;
      logic [2:0]  ix;
      logic [2:0]  bs;
      logic [1:0]  dsz;
      logic [31:0] disp;
      logic        oe;
      logic [2:0]  os;
      logic [31:0] ea;
      logic [2:0]  sg;
      logic        isr;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 30;

   // registers: EAX 1000, ECX 20, EDX 300, EBX 14000, ESP 50000,
   // EBP 600600, ESI 20070, EDI 30800 -> BX 4000 BP 0600 SI 0070 DI 0800
   localparam vec_t VECS [NV] = '{
      // R1 BX+SI+d8
      '{1'b0,2'd1,3'd0,2'd0,3'd0,3'd0,2'd1,32'h05,1'b0,3'd0,32'h4075,3'd3,1'b0,8'd1},
      // R1 R3 BP+SI+d16
      '{1'b0,2'd2,3'd2,2'd0,3'd0,3'd0,2'd2,32'h1234,1'b0,3'd0,32'h18A4,3'd2,1'b0,8'd3},
      // R1 R4 BP+DI-16
      '{1'b0,2'd1,3'd3,2'd0,3'd0,3'd0,2'd1,32'hF0,1'b0,3'd0,32'h0DF0,3'd2,1'b0,8'd4},
      // R1 SI
      '{1'b0,2'd0,3'd4,2'd0,3'd0,3'd0,2'd0,32'h0,1'b0,3'd0,32'h0070,3'd3,1'b0,8'd1},
      // R1 DI
      '{1'b0,2'd0,3'd5,2'd0,3'd0,3'd0,2'd0,32'h0,1'b0,3'd0,32'h0800,3'd3,1'b0,8'd1},
      // R3 BP+d8
      '{1'b0,2'd1,3'd6,2'd0,3'd0,3'd0,2'd1,32'h10,1'b0,3'd0,32'h0610,3'd2,1'b0,8'd3},
      // R2 disp16 alone
      '{1'b0,2'd0,3'd6,2'd0,3'd0,3'd0,2'd2,32'hBEEF,1'b0,3'd0,32'hBEEF,3'd3,1'b0,8'd2},
      // R1 BX
      '{1'b0,2'd0,3'd7,2'd0,3'd0,3'd0,2'd0,32'h0,1'b0,3'd0,32'h4000,3'd3,1'b0,8'd1},
      // R1 BX+DI+1
      '{1'b0,2'd2,3'd1,2'd0,3'd0,3'd0,2'd2,32'h1,1'b0,3'd0,32'h4801,3'd3,1'b0,8'd1},
      // R12 16-bit wrap
      '{1'b0,2'd2,3'd0,2'd0,3'd0,3'd0,2'd2,32'hC000,1'b0,3'd0,32'h0070,3'd3,1'b0,8'd12},
      // R4 byte sign extension in 16-bit
      '{1'b0,2'd1,3'd7,2'd0,3'd0,3'd0,2'd1,32'h80,1'b0,3'd0,32'h3F80,3'd3,1'b0,8'd4},
      // R5 register operand 16-bit
      '{1'b0,2'd3,3'd3,2'd0,3'd0,3'd0,2'd0,32'h0,1'b0,3'd0,32'h0,3'd3,1'b1,8'd5},
      // R5 register operand with override
      '{1'b1,2'd3,3'd5,2'd0,3'd0,3'd0,2'd0,32'h0,1'b1,3'd4,32'h0,3'd4,1'b1,8'd5},
      // R6 EAX
      '{1'b1,2'd0,3'd0,2'd0,3'd0,3'd0,2'd0,32'h0,1'b0,3'd0,32'h1000,3'd3,1'b0,8'd6},
      // R6 R10 EBP-1
      '{1'b1,2'd1,3'd5,2'd0,3'd0,3'd0,2'd1,32'hFF,1'b0,3'd0,32'h006005FF,3'd2,1'b0,8'd10},
      // R6 EDI+d32
      '{1'b1,2'd2,3'd7,2'd0,3'd0,3'd0,2'd3,32'h10000000,1'b0,3'd0,32'h10030800,3'd3,1'b0,8'd6},
      // R6 disp32 alone
      '{1'b1,2'd0,3'd5,2'd0,3'd0,3'd0,2'd3,32'hDEADBEEF,1'b0,3'd0,32'hDEADBEEF,3'd3,1'b0,8'd6},
      // R7 EAX+ECX*4
      '{1'b1,2'd0,3'd4,2'd2,3'd1,3'd0,2'd0,32'h0,1'b0,3'd0,32'h1080,3'd3,1'b0,8'd7},
      // R7 EBX+EDX*8+4
      '{1'b1,2'd1,3'd4,2'd3,3'd2,3'd3,2'd1,32'h04,1'b0,3'd0,32'h15804,3'd3,1'b0,8'd7},
      // R8 no index
      '{1'b1,2'd0,3'd4,2'd3,3'd4,3'd6,2'd0,32'h0,1'b0,3'd0,32'h20070,3'd3,1'b0,8'd8},
      // R9 no base with mod 00
      '{1'b1,2'd0,3'd4,2'd1,3'd1,3'd5,2'd3,32'h00100000,1'b0,3'd0,32'h00100040,3'd3,1'b0,8'd9},
      // R9 EBP base with mod 01
      '{1'b1,2'd1,3'd4,2'd0,3'd0,3'd5,2'd1,32'h08,1'b0,3'd0,32'h00601608,3'd2,1'b0,8'd9},
      // R10 ESP base
      '{1'b1,2'd0,3'd4,2'd0,3'd4,3'd4,2'd0,32'h0,1'b0,3'd0,32'h00050000,3'd2,1'b0,8'd10},
      // R10 EBP as index only gives DS
      '{1'b1,2'd0,3'd4,2'd0,3'd5,3'd0,2'd0,32'h0,1'b0,3'd0,32'h00601600,3'd3,1'b0,8'd10},
      // R12 32-bit wrap
      '{1'b1,2'd2,3'd4,2'd0,3'd4,3'd5,2'd3,32'hFFA00000,1'b0,3'd0,32'h00000600,3'd2,1'b0,8'd12},
      // R11 override in 16-bit
      '{1'b0,2'd0,3'd2,2'd0,3'd0,3'd0,2'd0,32'h0,1'b1,3'd0,32'h0670,3'd0,1'b0,8'd11},
      // R11 override in 32-bit
      '{1'b1,2'd0,3'd0,2'd0,3'd0,3'd0,2'd0,32'h0,1'b1,3'd5,32'h1000,3'd5,1'b0,8'd11},
      // R4 word zero extension in 32-bit
      '{1'b1,2'd2,3'd0,2'd0,3'd0,3'd0,2'd2,32'h8000,1'b0,3'd0,32'h9000,3'd3,1'b0,8'd4},
      // R4 size 0 ignores displacement bits
      '{1'b1,2'd0,3'd1,2'd0,3'd0,3'd0,2'd0,32'hFFFFFFFF,1'b0,3'd0,32'h20,3'd3,1'b0,8'd4},
      // R4 dword in 16-bit keeps low half
      '{1'b0,2'd0,3'd6,2'd0,3'd0,3'd0,2'd3,32'h12345678,1'b0,3'd0,32'h5678,3'd3,1'b0,8'd4}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode32 = 1'b0;
   logic [1:0]   mod_f = 2'd0;
   logic [2:0]   rm_f = 3'd0;
   logic [1:0]   sib_scale = 2'd0;
   logic [2:0]   sib_index = 3'd0;
   logic [2:0]   sib_base = 3'd0;
   logic [31:0]  disp_i = 32'd0;
   logic [1:0]   disp_sz = 2'd0;
   logic         seg_ovr_en = 1'b0;
   logic [2:0]   seg_ovr_sel = 3'd0;
   logic [255:0] gpr_flat;
   logic [31:0]  ea_o;
   logic [2:0]   seg_o;
   logic         is_reg_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   assign gpr_flat = {32'h00030800, 32'h00020070, 32'h00600600, 32'h00050000,
                      32'h00014000, 32'h00000300, 32'h00000020, 32'h00001000};

   always #10 clk = ~clk;

   eagen_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode32      (mode32),
      .mod_f       (mod_f),
      .rm_f        (rm_f),
      .sib_scale   (sib_scale),
      .sib_index   (sib_index),
      .sib_base    (sib_base),
      .disp_i      (disp_i),
      .disp_sz     (disp_sz),
      .seg_ovr_en  (seg_ovr_en),
      .seg_ovr_sel (seg_ovr_sel),
      .gpr_flat    (gpr_flat),
      .ea_o        (ea_o),
      .seg_o       (seg_o),
      .is_reg_o    (is_reg_o)
   );

   task automatic apply(input vec_t v);
      mode32      = v.m32;
      mod_f       = v.md;
      rm_f        = v.rm;
      sib_scale   = v.sc;
      sib_index   = v.ix;
      sib_base    = v.bs;
      disp_i      = v.disp;
      disp_sz     = v.dsz;
      seg_ovr_en  = v.oe;
      seg_ovr_sel = v.os;
   endtask

   task automatic check(input string tag, input logic [31:0] e_ea,
                        input logic [2:0] e_sg, input logic e_isr);
      total++;
      if (ea_o !== e_ea || seg_o !== e_sg || is_reg_o !== e_isr) begin
         bad++;
         $display("FAIL %s: ea=%h seg=%0d reg=%0b expected ea=%h seg=%0d reg=%0b",
                  tag, ea_o, seg_o, is_reg_o, e_ea, e_sg, e_isr);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      bad++;
      $display("FAIL watchdog: run did not end, expected end of stimulus");
      finish_run();
   end

   initial begin
      // R13 reset state while reset is held
      apply(VECS[0]);
      repeat (3) @(negedge clk);
      check("R13 reset held", 32'h0, 3'd0, 1'b0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VECS[i]);
         @(negedge clk);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ea, VECS[i].sg, VECS[i].isr);
      end

      // R13 previous result held until the capturing edge
      @(negedge clk);
      apply(VECS[13]);
      @(negedge clk);
      apply(VECS[7]);
      #5;
      check("R13 hold before edge", 32'h1000, 3'd3, 1'b0);
      @(negedge clk);
      check("R13 update after edge", 32'h4000, 3'd3, 1'b0);

      // R13 asynchronous reset mid-run
      #3;
      rst_n = 1'b0;
      #1;
      check("R13 async reset", 32'h0, 3'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13 after reset release", 32'h4000, 3'd3, 1'b0);

      // R8 R7 index 100 with scale 3 and base EAX: no index term
      apply('{1'b1,2'd0,3'd4,2'd3,3'd4,3'd0,2'd0,32'h0,1'b0,3'd0,32'h1000,3'd3,1'b0,8'd8});
      @(negedge clk);
      check("R8 index none base EAX", 32'h1000, 3'd3, 1'b0);

      // R9 no-base form with mod 10 adds EBP and selects SS
      apply('{1'b1,2'd2,3'd4,2'd0,3'd4,3'd5,2'd3,32'h0,1'b0,3'd0,32'h0,3'd0,1'b0,8'd9});
      @(negedge clk);
      check("R9 base 101 mod 10", 32'h00600600, 3'd2, 1'b0);

      finish_run();
   end

endmodule